// File: doc/BRIEF.md
# I2C Slave Address Matcher with Masking

This block sits behind the bit-level receiver of an I2C slave and decides, one byte at a time, whether the address byte just received should be acknowledged. A strobe marks each received byte. The decision is registered and appears one clock later. It stays on the output until the next byte or until the bus controller signals a stop or repeated start. The block handles both 7-bit and 10-bit addressing. In 10-bit mode, an input supplied by the bus controller tells the block whether the current byte is the first or the second byte of the address.

A per-bit mask register makes selected address positions don't-care. A bypass input switches the mask off and forces exact comparison. Some address patterns are reserved by the bus protocol. These are rejected on the raw received bits before any masking takes place, so no mask setting and no own-address value can turn a reserved pattern into a match. The all-zero address with a write bit is the general call. It is accepted only when the general-call enable is set. Two sticky flags are provided: one reports an accepted general call and one reports a complete 10-bit match. Both are cleared when a transfer ends.

Top module: `i2c_addr_matcher`

## Requirements
- R1: `ackOut` takes the decision for a byte on the clock edge that samples `byteValid` high, so it is visible one cycle after the strobe. Without a strobe or a bus reset, `ackOut` keeps its value.
- R2: In 7-bit mode, the address is `rxByte[7:1]`. It is compared with `ownAddr[6:0]`. The R/W bit `rxByte[0]` has no influence on an own-address match.
- R3: When `maskBypass` is 0, each bit of `addrMask` set to 1 makes the corresponding own-address bit a don't-care. Bits 6:0 apply in 7-bit mode. Bits 9:8 apply to the 10-bit first byte and bits 7:0 apply to the 10-bit second byte.
- R4: When `maskBypass` is 1, `addrMask` has no effect and the comparison is exact.
- R5: A first byte is never acknowledged when it has any of these 7-bit address values: 0000001, 0000010, 0000011, 00001xx or 11111xx. The same holds for the start byte, which is address 0000000 with R/W = 1. These rules hold regardless of `ownAddr`, `addrMask` and mode.
- R6: The first byte 0x00 (general call) is acknowledged, and sets `genCallHit`, exactly when `genCallEn` is 1. This is independent of the mask and of the own address, and it works in both modes.
- R7: In 7-bit mode, a first byte whose address has the form 11110xx is never acknowledged.
- R8: In 10-bit mode, a first byte of the form 11110 b9 b8 R/W is acknowledged when `rxByte[2:1]` matches `ownAddr[9:8]` under the mask. The R/W bit is ignored. This byte loads the internal upper-matched state.
- R9: In 10-bit mode, a byte marked with `secondByte` = 1 is acknowledged only if an upper byte has matched since the last bus reset and `rxByte` matches `ownAddr[7:0]` under the mask. When it is acknowledged, `tenBitHit` is set.
- R10: `busReset` clears `ackOut`, `genCallHit`, `tenBitHit` and the upper-matched state on the next edge. If `busReset` and `byteValid` arrive in the same cycle, `busReset` wins.
- R11: In 10-bit mode, a first byte that is neither a 11110xx header nor the general call is not acknowledged. It also clears the upper-matched state.
- R12: In 7-bit mode, `secondByte` is ignored and every strobed byte is decoded as an address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| byteValid | input | 1 | One-cycle strobe: `rxByte` holds a received byte |
| rxByte | input | 8 | Received byte, MSB first as on the bus |
| secondByte | input | 1 | 10-bit mode: 1 marks the second address byte |
| busReset | input | 1 | Stop or repeated start seen; clears match state |
| ownAddr | input | 10 | Own slave address (7-bit mode uses bits 6:0) |
| addrMask | input | 10 | 1 = don't-care at that address position |
| tenBitMode | input | 1 | 1 = 10-bit addressing, 0 = 7-bit |
| genCallEn | input | 1 | 1 = accept the general call |
| maskBypass | input | 1 | 1 = ignore `addrMask`, compare exactly |
| ackOut | output | 1 | Registered acknowledge decision for the last byte |
| genCallHit | output | 1 | Sticky: general call accepted in this transfer |
| tenBitHit | output | 1 | Sticky: both 10-bit address bytes matched |

## Verification
A stale or wrongly loaded upper-matched state is invisible on the first byte. It shows only when the following second byte is acknowledged or refused wrongly, one cycle after that byte's strobe. The bench therefore sends header/second-byte pairs with matching and non-matching headers, with and without bus resets between them. A bad reserved-pattern or mask decode shows at `ackOut` in the cycle after the offending byte. Sticky flags that are not cleared show in the cycle after `busReset`, including the case where `busReset` and the strobe coincide.

// File: rtl/addr_match_pkg.sv
package addr_match_pkg;
  localparam int BYTE_W   = 8;
  localparam int ADDR7_W  = BYTE_W - 1;
  localparam int ADDR10_W = 10;
  localparam int HI_W     = ADDR10_W - BYTE_W;
  localparam int PFX_W    = ADDR7_W - HI_W;

  // Five-bit prefixes of the 7-bit address field that carry protocol meaning
  localparam logic [PFX_W-1:0] TEN_HDR_PFX = 5'b11110;
  localparam logic [PFX_W-1:0] RSV_HI_PFX  = 5'b11111;
  localparam logic [PFX_W-1:0] RSV_LO_PFX  = 5'b00001;

  typedef struct packed {
    logic isStart;
    logic isGenCall;
    logic isReserved;
    logic isTenHdr;
    logic hdrMatch;
    logic sevenMatch;
    logic lowMatch;
  } byteClassT;

  typedef struct packed {
    logic clrAll;
    logic loadAck;
    logic ackVal;
    logic setGc;
    logic loadHi;
    logic hiVal;
    logic setTen;
  } strobeT;
endpackage

// File: rtl/addr_match_dp.sv
module addr_match_dp
  import addr_match_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [BYTE_W-1:0]   rxByte,
  input  logic [ADDR10_W-1:0] ownAddr,
  input  logic [ADDR10_W-1:0] addrMask,
  input  logic                maskBypass,
  input  strobeT              strb,
  output byteClassT           cls,
  output logic                hiMatched,
  output logic                ackOut,
  output logic                genCallHit,
  output logic                tenBitHit
);
  logic [ADDR10_W-1:0] effMask;
  logic [ADDR7_W-1:0]  addr7;
  logic [PFX_W-1:0]    prefix;
  logic [ADDR7_W-1:0]  sevenOk;
  logic [BYTE_W-1:0]   lowOk;
  logic [HI_W-1:0]     hdrOk;

  assign effMask = maskBypass ? '0 : addrMask;
  assign addr7   = rxByte[BYTE_W-1:1];
  assign prefix  = addr7[ADDR7_W-1:HI_W];

  // Per-bit don't-care comparators
  for (genvar i = 0; i < ADDR7_W; i++) begin : g_seven
    assign sevenOk[i] = effMask[i] | (addr7[i] ~^ ownAddr[i]);
  end
  for (genvar i = 0; i < BYTE_W; i++) begin : g_low
    assign lowOk[i] = effMask[i] | (rxByte[i] ~^ ownAddr[i]);
  end
  for (genvar i = 0; i < HI_W; i++) begin : g_hdr
    assign hdrOk[i] = effMask[BYTE_W+i] | (addr7[i] ~^ ownAddr[BYTE_W+i]);
  end

  // Reserved decoding works on raw bits, never on masked ones
  always_comb begin
    cls.isStart    = (addr7 == '0) &&  rxByte[0];
    cls.isGenCall  = (addr7 == '0) && !rxByte[0];
    cls.isReserved = ((prefix == '0) && (addr7[HI_W-1:0] != '0))
                   || (prefix == RSV_LO_PFX)
                   || (prefix == RSV_HI_PFX);
    cls.isTenHdr   = (prefix == TEN_HDR_PFX);
    cls.hdrMatch   = &hdrOk;
    cls.sevenMatch = &sevenOk;
    cls.lowMatch   = &lowOk;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackOut     <= 1'b0;
      genCallHit <= 1'b0;
      tenBitHit  <= 1'b0;
      hiMatched  <= 1'b0;
    end else if (strb.clrAll) begin
      ackOut     <= 1'b0;
      genCallHit <= 1'b0;
      tenBitHit  <= 1'b0;
      hiMatched  <= 1'b0;
    end else begin
      if (strb.loadAck) ackOut     <= strb.ackVal;
      if (strb.setGc)   genCallHit <= 1'b1;
      if (strb.loadHi)  hiMatched  <= strb.hiVal;
      if (strb.setTen)  tenBitHit  <= 1'b1;
    end
  end
endmodule

// File: rtl/addr_match_ctrl.sv
module addr_match_ctrl
  import addr_match_pkg::*;
(
  input  logic      byteValid,
  input  logic      secondByte,
  input  logic      busReset,
  input  logic      tenBitMode,
  input  logic      genCallEn,
  input  logic      hiMatched,
  input  byteClassT cls,
  output strobeT    strb
);
  logic isLowPhase;

  assign isLowPhase = tenBitMode && secondByte;

  always_comb begin
    strb        = '0;
    strb.clrAll = busReset;
    if (byteValid && !busReset) begin
      strb.loadAck = 1'b1;
      if (isLowPhase) begin
        strb.ackVal = hiMatched && cls.lowMatch;
        strb.setTen = strb.ackVal;
      end else begin
        strb.loadHi = tenBitMode;
        if (cls.isGenCall) begin
          strb.ackVal = genCallEn;
          strb.setGc  = genCallEn;
        end else if (cls.isStart || cls.isReserved) begin
          strb.ackVal = 1'b0;
        end else if (cls.isTenHdr) begin
          strb.ackVal = tenBitMode && cls.hdrMatch;
          strb.hiVal  = strb.ackVal;
        end else begin
          strb.ackVal = !tenBitMode && cls.sevenMatch;
        end
      end
    end
  end
endmodule

// File: rtl/i2c_addr_matcher.sv
module i2c_addr_matcher
  import addr_match_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                byteValid,
  input  logic [BYTE_W-1:0]   rxByte,
  input  logic                secondByte,
  input  logic                busReset,
  input  logic [ADDR10_W-1:0] ownAddr,
  input  logic [ADDR10_W-1:0] addrMask,
  input  logic                tenBitMode,
  input  logic                genCallEn,
  input  logic                maskBypass,
  output logic                ackOut,
  output logic                genCallHit,
  output logic                tenBitHit
);
  byteClassT cls;
  strobeT    strb;
  logic      hiMatched;

  addr_match_ctrl ctrl_i (
    .byteValid  (byteValid),
    .secondByte (secondByte),
    .busReset   (busReset),
    .tenBitMode (tenBitMode),
    .genCallEn  (genCallEn),
    .hiMatched  (hiMatched),
    .cls        (cls),
    .strb       (strb)
  );

  addr_match_dp dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .rxByte     (rxByte),
    .ownAddr    (ownAddr),
    .addrMask   (addrMask),
    .maskBypass (maskBypass),
    .strb       (strb),
    .cls        (cls),
    .hiMatched  (hiMatched),
    .ackOut     (ackOut),
    .genCallHit (genCallHit),
    .tenBitHit  (tenBitHit)
  );
endmodule

// File: rtl/addr_match_chk.sv
module addr_match_chk
  import addr_match_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              byteValid,
  input logic [BYTE_W-1:0] rxByte,
  input logic              secondByte,
  input logic              busReset,
  input logic              tenBitMode,
  input logic              genCallEn,
  input logic              ackOut,
  input logic              genCallHit,
  input logic              tenBitHit
);
  logic firstPhase;
  assign firstPhase = byteValid && !busReset && !(tenBitMode && secondByte);

  p_ack_needs_strobe_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackOut) |-> $past(byteValid && !busReset));

  p_ack_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!byteValid && !busReset) |=> $stable(ackOut));

  p_start_nack_r5: assert property (@(posedge clk) disable iff (!rstN)
    (firstPhase && rxByte == 8'h01) |=> !ackOut);

  p_rsv_hi_nack_r5: assert property (@(posedge clk) disable iff (!rstN)
    (firstPhase && rxByte[7:3] == 5'b11111) |=> !ackOut);

  p_rsv_lo_nack_r5: assert property (@(posedge clk) disable iff (!rstN)
    (firstPhase && rxByte[7:3] == 5'b00001) |=> !ackOut);

  p_gc_off_r6: assert property (@(posedge clk) disable iff (!rstN)
    (firstPhase && rxByte == 8'h00 && !genCallEn) |=> (!ackOut && !$rose(genCallHit)));

  p_hdr_7bit_nack_r7: assert property (@(posedge clk) disable iff (!rstN)
    (firstPhase && !tenBitMode && rxByte[7:3] == 5'b11110) |=> !ackOut);

  p_ten_after_low_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tenBitHit) |-> $past(byteValid && secondByte && tenBitMode && !busReset));

  p_bus_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    busReset |=> (!ackOut && !genCallHit && !tenBitHit));
endmodule

bind i2c_addr_matcher addr_match_chk chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .byteValid  (byteValid),
  .rxByte     (rxByte),
  .secondByte (secondByte),
  .busReset   (busReset),
  .tenBitMode (tenBitMode),
  .genCallEn  (genCallEn),
  .ackOut     (ackOut),
  .genCallHit (genCallHit),
  .tenBitHit  (tenBitHit)
);

// File: tb/i2c_addr_matcher_tb.sv
module i2c_addr_matcher_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       byteValid = 1'b0;
  logic [7:0] rxByte = '0;
  logic       secondByte = 1'b0;
  logic       busReset = 1'b0;
  logic [9:0] ownAddr = '0;
  logic [9:0] addrMask = '0;
  logic       tenBitMode = 1'b0;
  logic       genCallEn = 1'b0;
  logic       maskBypass = 1'b0;
  logic       ackOut, genCallHit, tenBitHit;

  int nChecks = 0;
  int nFails  = 0;

  typedef struct {
    logic  ack;
    logic  gc;
    logic  ten;
    string tag;
  } expT;
  expT expQ[$];

  // Reference state built from the requirements
  logic mAck = 1'b0, mGc = 1'b0, mTen = 1'b0, mHi = 1'b0;

  always #5 clk = ~clk;

  i2c_addr_matcher dut_i (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .rxByte(rxByte),
    .secondByte(secondByte), .busReset(busReset), .ownAddr(ownAddr),
    .addrMask(addrMask), .tenBitMode(tenBitMode), .genCallEn(genCallEn),
    .maskBypass(maskBypass), .ackOut(ackOut), .genCallHit(genCallHit),
    .tenBitHit(tenBitHit)
  );

  task automatic compare(input logic a, input logic g, input logic t, input string tag);
    nChecks++;
    if (ackOut !== a || genCallHit !== g || tenBitHit !== t) begin
      nFails++;
      $display("FAIL %s: ack/gc/ten actual %b%b%b expected %b%b%b",
               tag, ackOut, genCallHit, tenBitHit, a, g, t);
    end
  endtask

  function automatic logic maskedEq(input logic [9:0] rx, input logic [9:0] own,
                                    input logic [9:0] msk);
    logic [9:0] m;
    m = maskBypass ? 10'd0 : msk;
    return ((rx ^ own) & ~m) == 10'd0;
  endfunction

  task automatic model(input logic [7:0] b, input logic sec);
    logic [6:0] a7;
    a7 = b[7:1];
    if (tenBitMode && sec) begin
      mAck = mHi && maskedEq({2'b00, b}, {2'b00, ownAddr[7:0]}, {2'b00, addrMask[7:0]});
      if (mAck) mTen = 1'b1;
    end else begin
      if (tenBitMode) mHi = 1'b0;
      if (a7 == 7'd0) begin
        mAck = !b[0] && genCallEn;
        if (mAck) mGc = 1'b1;
      end else if (a7 <= 7'd3 || a7[6:2] == 5'b00001 || a7[6:2] == 5'b11111) begin
        mAck = 1'b0;
      end else if (a7[6:2] == 5'b11110) begin
        mAck = tenBitMode && maskedEq({8'd0, a7[1:0]}, {8'd0, ownAddr[9:8]},
                                      {8'd0, addrMask[9:8]});
        if (tenBitMode) mHi = mAck;
      end else begin
        mAck = !tenBitMode && maskedEq({3'd0, a7}, {3'd0, ownAddr[6:0]},
                                       {3'd0, addrMask[6:0]});
      end
    end
  endtask

  task automatic sendByte(input logic [7:0] b, input logic sec, input logic rst,
                          input string tag);
    expT e;
    @(posedge clk); #2;
    rxByte = b; secondByte = sec; byteValid = 1'b1; busReset = rst;
    if (rst) begin
      mAck = 0; mGc = 0; mTen = 0; mHi = 0;
    end else begin
      model(b, sec);
    end
    e.ack = mAck; e.gc = mGc; e.ten = mTen; e.tag = tag;
    expQ.push_back(e);
    @(posedge clk); #2;
    byteValid = 1'b0; busReset = 1'b0; secondByte = 1'b0;
  endtask

  task automatic pulseReset(input string tag);
    expT e;
    @(posedge clk); #2;
    busReset = 1'b1;
    mAck = 0; mGc = 0; mTen = 0; mHi = 0;
    e.ack = 0; e.gc = 0; e.ten = 0; e.tag = tag;
    expQ.push_back(e);
    @(posedge clk); #2;
    busReset = 1'b0;
  endtask

  // Monitor: a strobe seen at one falling edge is judged at the next
  logic pending = 1'b0;
  always @(negedge clk) begin
    if (pending) begin
      if (expQ.size() == 0) begin
        nChecks++; nFails++;
        $display("FAIL scoreboard: result with no expected item");
      end else begin
        expT e;
        e = expQ.pop_front();
        compare(e.ack, e.gc, e.ten, e.tag);
      end
    end
    pending = rstN && (byteValid || busReset);
  end

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #2_000_000;
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    @(negedge clk);
    compare(0, 0, 0, "reset state");

    // 7-bit own address 0x2A
    ownAddr = 10'h02A;
    sendByte(8'h54, 0, 0, "R2 write match");
    sendByte(8'h55, 0, 0, "R2 read match");
    sendByte(8'h56, 0, 0, "R2 mismatch");
    sendByte(8'h55, 0, 0, "R1 ack set");
    repeat (4) @(posedge clk);
    @(negedge clk);
    compare(1, 0, 0, "R1 hold without strobe");

    addrMask = 10'h020;
    sendByte(8'h14, 0, 0, "R3 masked bit");
    sendByte(8'h16, 0, 0, "R3 unmasked bit differs");
    maskBypass = 1'b1;
    sendByte(8'h14, 0, 0, "R4 bypass exact");
    sendByte(8'h54, 0, 0, "R4 bypass exact own");
    maskBypass = 1'b0;

    sendByte(8'h54, 1, 0, "R12 secondByte ignored");

    // Reserved patterns
    ownAddr = 10'h07C; addrMask = 10'h000;
    sendByte(8'hF8, 0, 0, "R5 11111xx own");
    ownAddr = 10'h003;
    sendByte(8'h06, 0, 0, "R5 0000011 own");
    addrMask = 10'h07F;
    sendByte(8'h08, 0, 0, "R5 00001xx masked");
    sendByte(8'h02, 0, 0, "R5 0000001 masked");
    sendByte(8'h01, 0, 0, "R5 start byte");
    sendByte(8'h80, 0, 0, "R3 full mask match");
    addrMask = 10'h000;

    // General call
    genCallEn = 1'b0;
    sendByte(8'h00, 0, 0, "R6 gc disabled");
    genCallEn = 1'b1;
    sendByte(8'h00, 0, 0, "R6 gc enabled");
    sendByte(8'h56, 0, 0, "R6 gc flag sticky");
    pulseReset("R10 clear after gc");

    // 7-bit mode header form
    ownAddr = 10'h078;
    sendByte(8'hF0, 0, 0, "R7 header in 7-bit mode");

    // 10-bit mode
    tenBitMode = 1'b1; ownAddr = 10'h2C5; addrMask = 10'h000;
    pulseReset("R10 start 10-bit");
    sendByte(8'hF4, 0, 0, "R8 header match");
    sendByte(8'hC5, 1, 0, "R9 low match");
    pulseReset("R10 clear ten flag");
    sendByte(8'hC5, 1, 0, "R9 low without header");
    sendByte(8'hF2, 0, 0, "R8 header mismatch");
    sendByte(8'hC5, 1, 0, "R9 low after bad header");
    sendByte(8'hF5, 0, 0, "R8 header read bit");
    sendByte(8'hC4, 1, 0, "R9 low mismatch");
    addrMask = 10'h101;
    sendByte(8'hF6, 0, 0, "R3 header masked bit8");
    sendByte(8'hC4, 1, 0, "R3 low masked bit0");
    maskBypass = 1'b1;
    pulseReset("R10 before bypass");
    sendByte(8'hF6, 0, 0, "R4 header bypass");
    sendByte(8'hF4, 0, 0, "R4 header exact");
    sendByte(8'hC4, 1, 0, "R4 low bypass");
    maskBypass = 1'b0; addrMask = 10'h000;
    sendByte(8'h54, 0, 0, "R11 7-bit style in 10-bit");
    sendByte(8'hC5, 1, 0, "R11 header state cleared");
    sendByte(8'h00, 0, 0, "R6 gc in 10-bit");
    sendByte(8'hF4, 0, 1, "R10 reset beats strobe");
    sendByte(8'hC5, 1, 0, "R10 no header after reset");

    repeat (3) @(posedge clk);
    @(negedge clk);
    if (expQ.size() != 0) begin
      nChecks++; nFails++;
      $display("FAIL scoreboard: %0d items left, expected 0", expQ.size());
    end
    finishRun();
  end
endmodule